// File: doc/BRIEF.md
# Forwarded-Clock Serial Master

This block is a single-target serial master with SPI-style signalling. It runs entirely on the fast system clock. The slow serial clock is not made by a clock generator. A phase counter builds it, and the block drives it to the pin alongside the data, so clock and data leave the chip through matching register stages. The serial clock is presented as a pair of per-cycle values. `sclk_rise` holds the level for the first half of a system cycle and `sclk_fall` holds the level for the second half. A dual-edge output stage can combine the two, so an odd divide ratio still yields a high time of exactly half a serial period.

A transfer starts with a start/ready handshake that also loads a parallel word. Chip select then goes low and the frame is shifted out most significant bit first. Inbound data is gathered in the system-clock domain at the internal edge matching each serial falling point. The received word appears together with a one-cycle completion strobe. The divide ratio is a parameter, from 2 (a fast target) up to 25 and beyond (a slow target).

Top module: `fcs_spi_master`

## Requirements
- R1: Let D be the divide ratio and H = floor(D/2). Within a serial bit period, cycle index c (0..D-1, where c = 0 is the cycle in which the clock rises) has `sclk_rise` = 1 when c < H, or when D is odd and c = H. In the same cycle, `sclk_fall` = 1 only when c < H. Successive rising points are exactly D cycles apart.
- R2: For an even D, `sclk_fall` equals `sclk_rise` in every cycle.
- R3: While `cs_n` is high, both serial clock phases are 0. After a start is accepted, `cs_n` is low for exactly D − H cycles before the first cycle in which `sclk_rise` is 1.
- R4: `mosi` carries the word most significant bit first. Bit 0 of the frame (`tx_word[W-1]`) is on `mosi` from the first cycle that `cs_n` is low. Inside a frame, `mosi` changes only in cycle c = H + (D mod 2), which is the first cycle with both phases 0 after the high time. After the last bit, `mosi` returns to 0.
- R5: `miso` is sampled on the system edge that ends cycle c = H + (D mod 2) − 1 of each bit. The first sample is the most significant bit of `rx_word`.
- R6: `done` is high for exactly one cycle, in the cycle after the last sample. In that cycle `rx_word` holds the full received word, and it keeps that value until the next frame completes.
- R7: `start` is accepted only while `ready` is 1. A start pulse during a frame changes no output of that frame. `ready` falls in the cycle after an accepted start and rises in the same cycle `cs_n` returns high.
- R8: `cs_n` returns high in the cycle after the last low cycle (c = D−1) of the final bit, so a new start is accepted at once.
- R9: A synchronous reset gives `cs_n` = 1, `ready` = 1, both clock phases 0, `mosi` = 0, `done` = 0 and `rx_word` = 0.
- R10: All of the above hold for any D ≥ 2, including D = 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a transfer (taken when ready is 1) |
| tx_word | input | FRAME_W | Word to transmit, loaded with start |
| ready | output | 1 | Idle, able to accept a start |
| rx_word | output | FRAME_W | Last received word |
| done | output | 1 | One-cycle completion strobe |
| miso | input | 1 | Serial data from the target |
| cs_n | output | 1 | Active-low chip select |
| sclk_rise | output | 1 | Serial clock level, first half of the system cycle |
| sclk_fall | output | 1 | Serial clock level, second half of the system cycle |
| mosi | output | 1 | Serial data to the target |

## Verification
The bound checker enforces the following on every cycle:
- the rising-point spacing;
- the nesting of the fall phase inside the rise phase, and their equality for even ratios;
- the lead time from chip select to the first rising point;
- that `mosi` moves only at the falling point;
- the single-cycle width of `done`;
- the handshake relation between `ready` and `cs_n`.

Only the bench scenarios can show that the bits come out in the right order, and that `miso` is taken at the correct edge rather than one cycle early or late. The bench shows this by flipping `miso` straight after the falling point. The same scenarios show that a start during a frame leaves both directions intact. The bench sweeps every 8-bit word at an odd ratio (5) and at the minimum ratio (2).

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LEAD = 2'd1,
    ST_XFER = 2'd2
  } fcs_state_e;
endpackage

// File: rtl/fcs_seq.sv
module fcs_seq
  import fcs_pkg::*;
#(
  parameter int DIV_RATIO = 25,
  parameter int FRAME_W   = 8,
  parameter int PW        = $clog2(DIV_RATIO)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          cs_n,
  output logic          ready,
  output logic          load_stb,
  output logic          cap_stb,
  output logic          last_cap,
  output logic          xfer_nxt,
  output logic [PW-1:0] ph_nxt
);
  localparam int HI     = DIV_RATIO / 2;
  localparam int ODD    = DIV_RATIO % 2;
  localparam int FALL_C = HI + ODD;
  localparam int LO     = DIV_RATIO - HI;
  localparam int BW     = (FRAME_W > 1) ? $clog2(FRAME_W) : 1;

  localparam logic [PW-1:0] LEAD_END = PW'(LO - 1);
  localparam logic [PW-1:0] PH_END   = PW'(DIV_RATIO - 1);
  localparam logic [PW-1:0] CAP_PH   = PW'(FALL_C - 1);
  localparam logic [BW-1:0] BIT_END  = BW'(FRAME_W - 1);

  fcs_state_e    st, st_n;
  logic [PW-1:0] ph, ph_n;
  logic [BW-1:0] bitc, bit_n;

  always_comb begin
    st_n  = st;
    ph_n  = ph;
    bit_n = bitc;
    unique case (st)
      ST_IDLE: begin
        if (start) begin
          st_n = ST_LEAD;
          ph_n = '0;
        end
      end
      ST_LEAD: begin
        if (ph == LEAD_END) begin
          st_n  = ST_XFER;
          ph_n  = '0;
          bit_n = '0;
        end else begin
          ph_n = ph + 1'b1;
        end
      end
      ST_XFER: begin
        if (ph == PH_END) begin
          ph_n = '0;
          if (bitc == BIT_END) st_n = ST_IDLE;
          else                 bit_n = bitc + 1'b1;
        end else begin
          ph_n = ph + 1'b1;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      ph    <= '0;
      bitc  <= '0;
      cs_n  <= 1'b1;
      ready <= 1'b1;
    end else begin
      st    <= st_n;
      ph    <= ph_n;
      bitc  <= bit_n;
      cs_n  <= (st_n == ST_IDLE);
      ready <= (st_n == ST_IDLE);
    end
  end

  assign load_stb = (st == ST_IDLE) && start;
  assign cap_stb  = (st == ST_XFER) && (ph == CAP_PH);
  assign last_cap = cap_stb && (bitc == BIT_END);
  assign xfer_nxt = (st_n == ST_XFER);
  assign ph_nxt   = ph_n;
endmodule

// File: rtl/fcs_sclk_shape.sv
module fcs_sclk_shape #(
  parameter int DIV_RATIO = 25,
  parameter int PW        = $clog2(DIV_RATIO)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          active,
  input  logic [PW-1:0] ph,
  output logic          rise_q,
  output logic          fall_q
);
  localparam int HI = DIV_RATIO / 2;
  localparam logic [PW-1:0] HI_P = PW'(HI);

  logic high_full;
  assign high_full = active && (ph < HI_P);

  generate
    if (DIV_RATIO % 2 == 1) begin : g_odd
      logic mid;
      assign mid = active && (ph == HI_P);
      always_ff @(posedge clk) begin
        if (rst) begin
          rise_q <= 1'b0;
          fall_q <= 1'b0;
        end else begin
          rise_q <= high_full || mid;
          fall_q <= high_full;
        end
      end
    end else begin : g_even
      always_ff @(posedge clk) begin
        if (rst) begin
          rise_q <= 1'b0;
          fall_q <= 1'b0;
        end else begin
          rise_q <= high_full;
          fall_q <= high_full;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/fcs_shift.sv
module fcs_shift #(
  parameter int FRAME_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [FRAME_W-1:0] tx,
  input  logic               cap,
  input  logic               last,
  input  logic               miso,
  output logic               mosi,
  output logic [FRAME_W-1:0] rx_word,
  output logic               done
);
  logic [FRAME_W-1:0] sreg;
  logic [FRAME_W-1:0] shifted;

  assign shifted = {sreg[FRAME_W-2:0], miso};

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg    <= '0;
      mosi    <= 1'b0;
      rx_word <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        sreg <= {tx[FRAME_W-2:0], 1'b0};
        mosi <= tx[FRAME_W-1];
      end else if (cap) begin
        sreg <= shifted;
        mosi <= last ? 1'b0 : sreg[FRAME_W-1];
        if (last) begin
          rx_word <= shifted;
          done    <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fcs_spi_master.sv
module fcs_spi_master
  import fcs_pkg::*;
#(
  parameter int DIV_RATIO = 25,
  parameter int FRAME_W   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [FRAME_W-1:0] tx_word,
  output logic               ready,
  output logic [FRAME_W-1:0] rx_word,
  output logic               done,
  input  logic               miso,
  output logic               cs_n,
  output logic               sclk_rise,
  output logic               sclk_fall,
  output logic               mosi
);
  localparam int PW = $clog2(DIV_RATIO);

  logic          load_stb, cap_stb, last_cap, xfer_nxt;
  logic [PW-1:0] ph_nxt;

  fcs_seq #(.DIV_RATIO(DIV_RATIO), .FRAME_W(FRAME_W), .PW(PW)) u_seq (
    .clk(clk), .rst(rst), .start(start),
    .cs_n(cs_n), .ready(ready),
    .load_stb(load_stb), .cap_stb(cap_stb), .last_cap(last_cap),
    .xfer_nxt(xfer_nxt), .ph_nxt(ph_nxt)
  );

  fcs_sclk_shape #(.DIV_RATIO(DIV_RATIO), .PW(PW)) u_shape (
    .clk(clk), .rst(rst), .active(xfer_nxt), .ph(ph_nxt),
    .rise_q(sclk_rise), .fall_q(sclk_fall)
  );

  fcs_shift #(.FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .rst(rst), .load(load_stb), .tx(tx_word),
    .cap(cap_stb), .last(last_cap), .miso(miso),
    .mosi(mosi), .rx_word(rx_word), .done(done)
  );
endmodule

// File: rtl/fcs_spi_master_chk.sv
module fcs_spi_master_chk #(
  parameter int DIV_RATIO = 25,
  parameter int FRAME_W   = 8
) (
  input logic clk,
  input logic rst,
  input logic start,
  input logic ready,
  input logic done,
  input logic cs_n,
  input logic sclk_rise,
  input logic sclk_fall,
  input logic mosi
);
  localparam int LO = DIV_RATIO - DIV_RATIO / 2;

  int   lead_cnt;
  logic seen_hi;
  int   gap;
  logic prev_rise;
  logic have_prev;

  always_ff @(posedge clk) begin
    if (rst || cs_n) begin
      lead_cnt  <= 0;
      seen_hi   <= 1'b0;
      gap       <= 0;
      prev_rise <= 1'b0;
      have_prev <= 1'b0;
    end else begin
      if (sclk_rise)     seen_hi  <= 1'b1;
      else if (!seen_hi) lead_cnt <= lead_cnt + 1;
      prev_rise <= sclk_rise;
      if (sclk_rise && !prev_rise) begin
        have_prev <= 1'b1;
        gap       <= 1;
      end else if (gap < DIV_RATIO + 1) begin
        gap <= gap + 1;
      end
    end
  end

  // R1: fall phase high only within a high rise phase
  p_fall_in_rise_r1: assert property (@(posedge clk) disable iff (rst)
    sclk_fall |-> sclk_rise);

  // R1, R10: rising points spaced by the divide ratio
  p_period_r1: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && sclk_rise && !prev_rise && have_prev) |-> (gap == DIV_RATIO));

  generate
    if (DIV_RATIO % 2 == 0) begin : g_even_chk
      // R2
      p_even_match_r2: assert property (@(posedge clk) disable iff (rst)
        sclk_fall == sclk_rise);
    end
  endgenerate

  // R3: idle clock low
  p_idle_low_r3: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> (!sclk_rise && !sclk_fall));

  // R3: lead time before the first rising point
  p_lead_r3: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && sclk_rise && !seen_hi) |-> (lead_cnt == LO));

  // R4: data moves only at the falling point
  p_mosi_edge_r4: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !$past(cs_n) && (mosi != $past(mosi))) |-> ($past(sclk_rise) && !sclk_rise));

  // R6
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_in_frame_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> !cs_n);

  // R7
  p_start_taken_r7: assert property (@(posedge clk) disable iff (rst)
    (ready && start) |=> (!ready && !cs_n));
  p_ready_with_cs_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> $rose(ready));
endmodule

bind fcs_spi_master fcs_spi_master_chk #(.DIV_RATIO(DIV_RATIO), .FRAME_W(FRAME_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .ready(ready), .done(done),
  .cs_n(cs_n), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .mosi(mosi)
);

// File: tb/fcs_spi_master_test.sv
module fcs_harness #(
  parameter int DIV = 5
) (
  input  logic clk,
  input  logic rst,
  output int   n_chk,
  output int   n_bad,
  output logic fin
);
  localparam int W      = 8;
  localparam int HI     = DIV / 2;
  localparam int FALL_C = HI + DIV % 2;
  localparam int LO     = DIV - HI;
  localparam int TOTAL  = LO + W * DIV + 1;

  logic         start, miso;
  logic [W-1:0] tx_word, rx_word;
  logic         ready, done, cs_n, sclk_rise, sclk_fall, mosi;

  fcs_spi_master #(.DIV_RATIO(DIV), .FRAME_W(W)) uut (
    .clk(clk), .rst(rst), .start(start), .tx_word(tx_word),
    .ready(ready), .rx_word(rx_word), .done(done), .miso(miso),
    .cs_n(cs_n), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .mosi(mosi)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s div=%0d t=%0t act=%0h exp=%0h", req, DIV, $time, act, exp);
    end
  endtask

  task automatic run_frame(input logic [W-1:0] tx, input logic [W-1:0] rxw, input bit glitch);
    start   = 1'b1;
    tx_word = tx;
    for (int t = 1; t <= TOTAL; t++) begin
      @(negedge clk);
      if (t == 1) begin
        start   = 1'b0;
        tx_word = ~tx;
      end
      if (t <= LO) begin
        chk("R3 cs_n lead", {31'd0, cs_n}, 0);
        chk("R7 ready low", {31'd0, ready}, 0);
        chk("R3 sclk_rise lead", {31'd0, sclk_rise}, 0);
        chk("R3 sclk_fall lead", {31'd0, sclk_fall}, 0);
        chk("R4 first bit", {31'd0, mosi}, {31'd0, tx[W-1]});
        chk("R6 done low", {31'd0, done}, 0);
      end else if (t < TOTAL) begin
        int  u, k, c;
        bit  er, ef, em;
        u  = t - LO - 1;
        k  = u / DIV;
        c  = u % DIV;
        er = (c < HI) || ((DIV % 2 == 1) && c == HI);
        ef = (c < HI);
        if (c < FALL_C)   em = tx[W-1-k];
        else if (k < W-1) em = tx[W-2-k];
        else              em = 1'b0;
        chk("R8 cs_n frame", {31'd0, cs_n}, 0);
        chk("R7 ready busy", {31'd0, ready}, 0);
        chk("R1 sclk_rise", {31'd0, sclk_rise}, {31'd0, er});
        chk(DIV % 2 == 0 ? "R2 sclk_fall" : "R1 sclk_fall", {31'd0, sclk_fall}, {31'd0, ef});
        chk("R4 mosi", {31'd0, mosi}, {31'd0, em});
        if (k == W-1 && c == FALL_C) begin
          chk("R6 done", {31'd0, done}, 1);
          chk("R5 rx_word", {24'd0, rx_word}, {24'd0, rxw});
        end else begin
          chk("R6 done idle", {31'd0, done}, 0);
        end
        if (c == 0)      miso = rxw[W-1-k];
        if (c == FALL_C) miso = ~rxw[W-1-k];
      end else begin
        chk("R8 cs_n end", {31'd0, cs_n}, 1);
        chk("R7 ready end", {31'd0, ready}, 1);
        chk("R3 idle sclk", {30'd0, sclk_rise, sclk_fall}, 0);
        chk("R4 mosi idle", {31'd0, mosi}, 0);
        chk("R6 rx_word held", {24'd0, rx_word}, {24'd0, rxw});
      end
      if (glitch && t == LO + 2) begin
        start   = 1'b1;
        tx_word = tx ^ 8'h3C;
      end
      if (glitch && t == LO + 3) start = 1'b0;
    end
  endtask

  initial begin
    n_chk   = 0;
    n_bad   = 0;
    fin     = 1'b0;
    start   = 1'b0;
    miso    = 1'b0;
    tx_word = '0;
    repeat (2) @(negedge clk);
    // R9 reset state
    chk("R9 cs_n", {31'd0, cs_n}, 1);
    chk("R9 ready", {31'd0, ready}, 1);
    chk("R9 sclk", {30'd0, sclk_rise, sclk_fall}, 0);
    chk("R9 mosi", {31'd0, mosi}, 0);
    chk("R9 done", {31'd0, done}, 0);
    chk("R9 rx_word", {24'd0, rx_word}, 0);
    while (rst) @(negedge clk);
    @(negedge clk);
    // R10: full word sweep at this ratio; R7 start glitches on some frames
    for (int v = 0; v < 256; v++) begin
      logic [W-1:0] rxv;
      rxv = W'((v * 37 + 11) % 256);
      run_frame(W'(v), rxv, (v % 7) == 3);
    end
    fin = 1'b1;
  end
endmodule

module fcs_spi_master_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  int   c_odd, b_odd, c_two, b_two;
  logic f_odd, f_two;
  bit   reported = 0;

  always #4 clk = ~clk;

  fcs_harness #(.DIV(5)) h_odd (.clk(clk), .rst(rst), .n_chk(c_odd), .n_bad(b_odd), .fin(f_odd));
  fcs_harness #(.DIV(2)) h_two (.clk(clk), .rst(rst), .n_chk(c_two), .n_bad(b_two), .fin(f_two));

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  end

  initial begin
    @(negedge clk);
    wait (f_odd && f_two);
    @(negedge clk);
    if (!reported) begin
      reported = 1;
      $display("== %0d vectors applied, %0d miscompares ==", c_odd + c_two, b_odd + b_two);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!reported) begin
      reported = 1;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", c_odd + c_two + 1, b_odd + b_two + 1);
      $finish;
    end
  end
endmodule